// File: doc/BRIEF.md
# Multi-drop UART Receiver with Address Filtering

This block receives asynchronous serial frames from a line that several receivers share. A transmitter on that line marks each frame as an address frame or a data frame. While the filter is enabled, the receiver keeps only address frames. Software reads each address byte and decides whether it is being selected. If it is, software clears the filter, and the frames that follow are then received normally. The block does not compare addresses itself.

Frames carry 8 or 9 data bits, chosen by `nine_bit_i`. In 9-bit mode the ninth bit is the address/data marker and the stop bit must be high. In 8-bit mode the stop bit is the marker, so a data frame received with the filter off also raises the framing-error flag. Each bit is decided by a majority vote over three oversampled ticks around mid-bit.

The control FSM has these states:
- `ST_IDLE`: waits for a low sample on a tick, then goes to `ST_START`.
- `ST_START`: checks the start bit at mid-bit. A high vote returns to `ST_IDLE`; a low vote goes to `ST_DATA`.
- `ST_DATA`: shifts in 8 bits. After the last one it goes to `ST_NINTH` in 9-bit mode, otherwise to `ST_STOP`.
- `ST_NINTH`: captures the ninth bit, then goes to `ST_STOP`.
- `ST_STOP`: votes the stop bit, completes the frame, then goes to `ST_TAIL`.
- `ST_TAIL`: waits for the end of the stop bit, then returns to `ST_IDLE`.

Top module: `mp_uart_rx`

## Requirements
- R1: A synchronous active-high `rst` clears `data_o`, `bit9_o`, `rxc_o`, `fe_o` and `filt_o` one cycle later, and returns the FSM to idle.
- R2: A frame is a low start bit, then 8 data bits sent LSB first, then a ninth bit in 9-bit mode, then the stop bit. Each bit lasts 16 `tick_i` pulses. The bit value is the majority of that bit's ticks 7, 8 and 9, counting from 1, so a single-tick glitch does not change it.
- R3: A start bit that votes high at mid-bit is discarded and leaves all outputs untouched. The receiver then accepts the next valid frame.
- R4: With the filter off, every completed frame loads `data_o` and sets `rxc_o`. `fe_o` is set when the stop bit is low and cleared when it is high.
- R5: In 9-bit mode the ninth bit is copied to `bit9_o`, and a value of 1 marks an address frame. A low stop bit still sets `fe_o`.
- R6: In 8-bit mode the stop bit is the marker: 1 means address, 0 means data. A data frame with the filter off sets both `rxc_o` and `fe_o`. An accepted 8-bit frame clears `bit9_o`.
- R7: With the filter on, an address frame is accepted exactly as in R4.
- R8: With the filter on, a data frame changes none of `data_o`, `bit9_o`, `rxc_o` or `fe_o`.
- R9: A one-cycle `rd_i` pulse clears `rxc_o` on the next cycle. A frame accepted in the same cycle wins and leaves `rxc_o` set.
- R10: A `filt_wr_i` pulse loads `filt_val_i` into `filt_o` on the next cycle. Each frame is filtered by the `filt_o` value held when its start bit was detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial line, asynchronous |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| filt_wr_i | input | 1 | One-cycle write strobe for the filter enable |
| filt_val_i | input | 1 | Value written to the filter enable |
| rd_i | input | 1 | Data-read strobe; clears `rxc_o` |
| data_o | output | DATA_W | Last accepted data byte |
| bit9_o | output | 1 | Ninth bit of the last accepted frame |
| rxc_o | output | 1 | Receive-complete flag |
| fe_o | output | 1 | Framing error of the last accepted frame |
| filt_o | output | 1 | Current filter enable |

## Verification
The bench targets the following corner cases:
- **8-bit stop-bit marker.** A design that reads the marker from the wrong place would drop addresses or accept data frames.
- **Framing error on 8-bit data frames.** The framing error raised by an 8-bit data frame received unfiltered must appear; a design that treated the low stop as the marker only would never report it.
- **Dropped frame with `rxc_o` already set.** A dropped data frame must leave a set `rxc_o` and the old byte alone; a design that updated registers before filtering would overwrite them.
- **Filter cleared mid-frame.** The current frame must still be dropped; a design that filtered with the live value would accept it.
- **Glitched start and glitched data bit.** A short low pulse must be rejected, and a one-tick glitch inside a data bit must be voted out; a single-sample design would decode a false frame or a flipped bit.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP,
        ST_TAIL
    } rx_state_e;
endpackage

// File: rtl/mp_uart_rx_sync.sv
module mp_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mp_uart_rx_sampler.sv
module mp_uart_rx_sampler #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic rx_i,
    input  logic arm_i,
    input  logic run_i,
    output logic vote_o,
    output logic vote_val_o,
    output logic wrap_o
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    logic [CW-1:0] cnt_q;
    logic [1:0]    early_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            early_q <= '0;
        end else if (tick_i) begin
            if (arm_i)
                cnt_q <= CW'(1);
            else if (run_i)
                cnt_q <= (cnt_q == CW'(OSR-1)) ? '0 : cnt_q + CW'(1);
            if (run_i && cnt_q == CW'(MID-2)) early_q[0] <= rx_i;
            if (run_i && cnt_q == CW'(MID-1)) early_q[1] <= rx_i;
        end
    end

    assign vote_o     = tick_i && run_i && (cnt_q == CW'(MID));
    assign vote_val_o = (early_q[0] & early_q[1]) | (early_q[0] & rx_i) | (early_q[1] & rx_i);
    assign wrap_o     = tick_i && run_i && (cnt_q == CW'(OSR-1));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mp_uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              nine_bit_i,
    input  logic              filt_wr_i,
    input  logic              filt_val_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              rxc_o,
    output logic              fe_o,
    output logic              filt_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         st_q, st_n;
    logic              rx_s;
    logic              start_seen, run;
    logic              vote, vote_val, wrap;
    logic              frame_filt_q, frame_nine_q, ninth_q;
    logic [IW-1:0]     bit_idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              marker, done_p, keep_p;

    mp_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    assign start_seen = (st_q == ST_IDLE) && tick_i && !rx_s;
    assign run        = (st_q != ST_IDLE);

    mp_uart_rx_sampler #(.OSR(OSR)) u_samp (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .rx_i       (rx_s),
        .arm_i      (start_seen),
        .run_i      (run),
        .vote_o     (vote),
        .vote_val_o (vote_val),
        .wrap_o     (wrap)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_n;
    end

    // transitions
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_seen) st_n = ST_START;
            ST_START: if (vote) st_n = vote_val ? ST_IDLE : ST_DATA;
            ST_DATA:  if (vote && bit_idx_q == IW'(DATA_W-1))
                          st_n = frame_nine_q ? ST_NINTH : ST_STOP;
            ST_NINTH: if (vote) st_n = ST_STOP;
            ST_STOP:  if (vote) st_n = ST_TAIL;
            ST_TAIL:  if (wrap) st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    // per-frame capture
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_filt_q <= 1'b0;
            frame_nine_q <= 1'b0;
            ninth_q      <= 1'b0;
            bit_idx_q    <= '0;
            shreg_q      <= '0;
        end else begin
            if (start_seen) begin
                frame_filt_q <= filt_o;
                frame_nine_q <= nine_bit_i;
                bit_idx_q    <= '0;
            end
            if (vote && st_q == ST_DATA) begin
                shreg_q   <= {vote_val, shreg_q[DATA_W-1:1]};
                bit_idx_q <= bit_idx_q + IW'(1);
            end
            if (vote && st_q == ST_NINTH) ninth_q <= vote_val;
        end
    end

    assign done_p = (st_q == ST_STOP) && vote;
    assign marker = frame_nine_q ? ninth_q : vote_val;
    assign keep_p = done_p && (!frame_filt_q || marker);

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            bit9_o <= 1'b0;
            rxc_o  <= 1'b0;
            fe_o   <= 1'b0;
            filt_o <= 1'b0;
        end else begin
            if (keep_p) begin
                data_o <= shreg_q;
                bit9_o <= frame_nine_q & ninth_q;
                fe_o   <= !vote_val;
                rxc_o  <= 1'b1;
            end else if (rd_i) begin
                rxc_o  <= 1'b0;
            end
            if (filt_wr_i) filt_o <= filt_val_i;
        end
    end
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_i,
    input logic              filt_wr_i,
    input logic              filt_val_i,
    input logic              done_p,
    input logic              keep_p,
    input logic [DATA_W-1:0] data_o,
    input logic              bit9_o,
    input logic              rxc_o,
    input logic              fe_o,
    input logic              filt_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!rxc_o && !fe_o && !bit9_o && !filt_o && data_o == '0)); // R1

    AST_ACCEPT_SETS_RXC: assert property (@(posedge clk) disable iff (rst)
        keep_p |=> rxc_o); // R4

    AST_DATA_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_o) |-> $past(keep_p)); // R4

    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_p && !keep_p) |=> ($stable(data_o) && $stable(fe_o) && $stable(bit9_o)
                                 && rxc_o == ($past(rxc_o) && !$past(rd_i)))); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !keep_p) |=> !rxc_o); // R9

    AST_FILT_LOAD: assert property (@(posedge clk) disable iff (rst)
        filt_wr_i |=> (filt_o == $past(filt_val_i))); // R10
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (rd_i),
    .filt_wr_i  (filt_wr_i),
    .filt_val_i (filt_val_i),
    .done_p     (done_p),
    .keep_p     (keep_p),
    .data_o     (data_o),
    .bit9_o     (bit9_o),
    .rxc_o      (rxc_o),
    .fe_o       (fe_o),
    .filt_o     (filt_o)
);

// File: tb/mp_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mp_uart_rx_tb_top;
    localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       nine_bit_i = 1'b0;
    logic       filt_wr_i = 1'b0;
    logic       filt_val_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] data_o;
    logic       bit9_o, rxc_o, fe_o, filt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mp_uart_rx dut_i (
        .clk(clk), .rst(rst), .rx_i(rx_i), .tick_i(tick_i),
        .nine_bit_i(nine_bit_i), .filt_wr_i(filt_wr_i), .filt_val_i(filt_val_i),
        .rd_i(rd_i), .data_o(data_o), .bit9_o(bit9_o), .rxc_o(rxc_o),
        .fe_o(fe_o), .filt_o(filt_o)
    );

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            tick_i = (cnt == 3);
            cnt = (cnt + 1) % 4;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_i = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic nine, input logic b9,
                        input logic stop, input int glitch_bit);
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            if (i == glitch_bit) begin
                hold(d[i], 28); hold(~d[i], 4); hold(d[i], BIT_CLKS-32);
            end else begin
                hold(d[i], BIT_CLKS);
            end
        end
        if (nine) hold(b9, BIT_CLKS);
        hold(stop, BIT_CLKS);
        hold(1'b1, 3*BIT_CLKS);
    endtask

    task automatic pulse_rd();
        rd_i = 1'b1; @(negedge clk); rd_i = 1'b0; @(negedge clk);
    endtask

    task automatic write_filt(input logic v);
        filt_val_i = v; filt_wr_i = 1'b1; @(negedge clk);
        filt_wr_i = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data", data_o, 0);
        chk("R1 rxc", rxc_o, 0);
        chk("R1 fe", fe_o, 0);
        chk("R1 bit9", bit9_o, 0);
        chk("R1 filt", filt_o, 0);
    endtask

    task automatic t_plain8();
        nine_bit_i = 1'b0;
        send(8'hA5, 1'b0, 1'b0, 1'b1, -1);
        chk("R2 data LSB first", data_o, 'hA5);
        chk("R4 rxc", rxc_o, 1);
        chk("R4 fe clear", fe_o, 0);
        pulse_rd();
        chk("R9 rd clears rxc", rxc_o, 0);
    endtask

    task automatic t_data8_fe();
        send(8'h3C, 1'b0, 1'b0, 1'b0, -1);
        chk("R6 data", data_o, 'h3C);
        chk("R6 rxc", rxc_o, 1);
        chk("R6 fe set", fe_o, 1);
        pulse_rd();
    endtask

    task automatic t_false_start();
        hold(1'b0, 8);
        hold(1'b1, 3*BIT_CLKS);
        chk("R3 no rxc", rxc_o, 0);
        chk("R3 data kept", data_o, 'h3C);
        send(8'h81, 1'b0, 1'b0, 1'b1, -1);
        chk("R3 next frame", data_o, 'h81);
        chk("R3 fe", fe_o, 0);
        pulse_rd();
    endtask

    task automatic t_majority();
        send(8'h55, 1'b0, 1'b0, 1'b1, 3);
        chk("R2 glitch voted out", data_o, 'h55);
        pulse_rd();
    endtask

    task automatic t_filter8();
        write_filt(1'b1);
        chk("R10 filt set", filt_o, 1);
        send(8'hF0, 1'b0, 1'b0, 1'b0, -1);
        chk("R8 data kept", data_o, 'h55);
        chk("R8 rxc kept", rxc_o, 0);
        chk("R8 fe kept", fe_o, 0);
        send(8'h12, 1'b0, 1'b0, 1'b1, -1);
        chk("R7 addr data", data_o, 'h12);
        chk("R7 addr rxc", rxc_o, 1);
        send(8'h99, 1'b0, 1'b0, 1'b0, -1);
        chk("R8 rxc stays set", rxc_o, 1);
        chk("R8 data kept 2", data_o, 'h12);
        chk("R8 fe kept 2", fe_o, 0);
        pulse_rd();
    endtask

    task automatic t_filter9();
        nine_bit_i = 1'b1;
        send(8'h77, 1'b1, 1'b0, 1'b1, -1);
        chk("R8 9b data dropped", data_o, 'h12);
        chk("R8 9b rxc", rxc_o, 0);
        send(8'h34, 1'b1, 1'b1, 1'b1, -1);
        chk("R5 addr data", data_o, 'h34);
        chk("R5 bit9", bit9_o, 1);
        chk("R7 9b rxc", rxc_o, 1);
        pulse_rd();
    endtask

    task automatic t_mid_change();
        fork
            send(8'h66, 1'b1, 1'b0, 1'b1, -1);
            begin
                repeat (200) @(negedge clk);
                write_filt(1'b0);
            end
        join
        chk("R10 filt cleared", filt_o, 0);
        chk("R10 frame still dropped", data_o, 'h34);
        send(8'h66, 1'b1, 1'b0, 1'b1, -1);
        chk("R5 data frame", data_o, 'h66);
        chk("R5 bit9 zero", bit9_o, 0);
        chk("R4 9b fe", fe_o, 0);
        pulse_rd();
    endtask

    task automatic t_stop_low9();
        send(8'h0F, 1'b1, 1'b1, 1'b0, -1);
        chk("R5 stop low fe", fe_o, 1);
        chk("R5 bit9", bit9_o, 1);
        pulse_rd();
        nine_bit_i = 1'b0;
        send(8'h42, 1'b0, 1'b0, 1'b1, -1);
        chk("R6 bit9 cleared", bit9_o, 0);
        chk("R6 data", data_o, 'h42);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain8();
        t_data8_fe();
        t_false_start();
        t_majority();
        t_filter8();
        t_filter9();
        t_mid_change();
        t_stop_low9();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end
endmodule